// File: doc/BRIEF.md
# Carry-Select-Before-Sum Adder Stage

This block adds two unsigned WIDTH-bit operands and a one-bit carry-in with no clock and no storage. It first forms the bitwise half-sum (XOR) and half-carry (AND) words. From those it builds two complete carry words in parallel. One assumes an incoming carry of 0 and the other assumes an incoming carry of 1.

The real carry-in then picks one of the two carry words. The final sum is formed only after that pick, by a single row of XORs. The carry-out is the top bit of the picked carry word, so it settles before the sum does.

The selector uses one AND-OR gate per bit instead of a multiplexer. This works because every bit set in the zero-assumption carry word is also set in the one-assumption carry word. The stage is meant to be chained, or used alone, wherever an early carry-out shortens the critical path.

Top module: `csb_adder`

## Requirements
- R1: For every input combination, the value {cout, sum} equals a + b + cin as an unsigned (WIDTH+1)-bit result.
- R2: Bit 0 of sum equals a[0] XOR b[0] XOR cin.
- R3: For fixed a and b, raising cin from 0 to 1 never clears cout. Inside the block, every bit set in the zero-assumption carry word is also set in the one-assumption carry word.
- R4: With cin = 0, the internally selected carry word equals the zero-assumption carry word. With cin = 1, it equals the one-assumption carry word.
- R5: When b is the bitwise inverse of a, the result follows cin. With cin = 1 the result is sum all zeros and cout = 1. With cin = 0 the result is sum all ones and cout = 0.
- R6: When a[WIDTH-1] and b[WIDTH-1] are both 1, cout is 1 whatever the other inputs are.
- R7: When a[WIDTH-1] and b[WIDTH-1] are both 0, cout is 0 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Incoming carry |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Top bit of a + b + cin, taken from the selected carry word |

## Verification
The checks are immediate and combinational. They assume the operands and carry-in are fully known two-state values, and they assume the results are read only once the carry words have settled. The bench meets both assumptions. It drives every input bit, including the carry-in, at a clock edge, and it compares results only at the following falling edge, well after the network has settled. It never leaves an input undriven.

// File: rtl/csb_pkg.sv
// Package: shared constants for the carry-select-before-sum adder.
// Assumes nothing; holds only elaboration-time limits.
package csb_pkg;
    localparam int unsigned MIN_WIDTH = 2;
endpackage

// File: rtl/csb_half_words.sv
// Module: bitwise half-sum and half-carry generation.
// Assumes both operands share the width WIDTH.
module csb_half_words #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] half_sum,
    output logic [WIDTH-1:0] half_carry
);
    // Per-bit propagate and generate terms.
    always_comb begin
        half_sum   = a ^ b;
        half_carry = a & b;
    end
endmodule

// File: rtl/csb_carry_chain.sv
// Module: one anticipated carry word for a fixed assumed incoming carry.
// Assumes WIDTH >= 2. SEED picks the reduced bit-0 form at elaboration.
module csb_carry_chain #(
    parameter int unsigned WIDTH = 16,
    parameter bit          SEED  = 1'b0
) (
    input  logic [WIDTH-1:0] half_sum,
    input  logic [WIDTH-1:0] half_carry,
    output logic [WIDTH-1:0] carry
);
    // Bit 0: the fixed seed folds into the generate/propagate terms.
    if (SEED) begin : g_seed_one
        assign carry[0] = half_sum[0] | half_carry[0];
    end else begin : g_seed_zero
        assign carry[0] = half_carry[0];
    end

    // Upper bits: ripple generate-or-propagate.
    for (genvar i = 1; i < WIDTH; i++) begin : g_link
        assign carry[i] = (carry[i-1] & half_sum[i]) | half_carry[i];
    end
endmodule

// File: rtl/csb_carry_pick.sv
// Module: AND-OR selection between the two anticipated carry words.
// Assumes carry_zero implies carry_one bit by bit, so no mux is needed.
module csb_carry_pick #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] carry_zero,
    input  logic [WIDTH-1:0] carry_one,
    input  logic             cin,
    output logic [WIDTH-1:0] carry_sel
);
    // One AND-OR gate per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pick
        assign carry_sel[i] = carry_zero[i] | (cin & carry_one[i]);
    end
endmodule

// File: rtl/csb_sum_row.sv
// Module: the single final-sum XOR row.
// Assumes carry_sel is the carry word already chosen for the real cin.
module csb_sum_row #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] half_sum,
    input  logic [WIDTH-1:0] carry_sel,
    input  logic             cin,
    output logic [WIDTH-1:0] sum
);
    // Bit 0 takes the real carry-in directly.
    assign sum[0] = half_sum[0] ^ cin;

    // Upper bits take the selected carry from the bit below.
    for (genvar i = 1; i < WIDTH; i++) begin : g_xor
        assign sum[i] = half_sum[i] ^ carry_sel[i-1];
    end
endmodule

// File: rtl/csb_adder.sv
// Module: top of the carry-select-before-sum adder stage.
// Purely combinational. WIDTH must be at least csb_pkg::MIN_WIDTH.
module csb_adder #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned MSB = WIDTH - 1;

    if (WIDTH < csb_pkg::MIN_WIDTH) begin : g_width_bad
        $error("csb_adder: WIDTH below minimum");
    end

    logic [WIDTH-1:0] half_sum;
    logic [WIDTH-1:0] half_carry;
    logic [WIDTH-1:0] carry_zero;
    logic [WIDTH-1:0] carry_one;
    logic [WIDTH-1:0] carry_sel;

    csb_half_words #(.WIDTH(WIDTH)) u_half (
        .a          (a),
        .b          (b),
        .half_sum   (half_sum),
        .half_carry (half_carry)
    );

    csb_carry_chain #(.WIDTH(WIDTH), .SEED(1'b0)) u_chain_zero (
        .half_sum   (half_sum),
        .half_carry (half_carry),
        .carry      (carry_zero)
    );

    csb_carry_chain #(.WIDTH(WIDTH), .SEED(1'b1)) u_chain_one (
        .half_sum   (half_sum),
        .half_carry (half_carry),
        .carry      (carry_one)
    );

    csb_carry_pick #(.WIDTH(WIDTH)) u_pick (
        .carry_zero (carry_zero),
        .carry_one  (carry_one),
        .cin        (cin),
        .carry_sel  (carry_sel)
    );

    csb_sum_row #(.WIDTH(WIDTH)) u_sum (
        .half_sum  (half_sum),
        .carry_sel (carry_sel),
        .cin       (cin),
        .sum       (sum)
    );

    // Carry-out leaves straight from the selector, ahead of the sum row.
    assign cout = carry_sel[MSB];
endmodule

// File: rtl/csb_adder_chk.sv
// Module: assertion checker bound to csb_adder.
// Assumes two-state, settled inputs; uses immediate combinational checks.
module csb_adder_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [WIDTH-1:0] carry_zero,
    input logic [WIDTH-1:0] carry_one,
    input logic [WIDTH-1:0] carry_sel
);
    logic [WIDTH:0] ref_total;

    // Arithmetic reference for the whole result.
    assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    // Combinational checks on ports and internal carry words.
    always_comb begin
        assert_total_R1: assert ({cout, sum} == ref_total);
        assert_lsb_R2: assert (sum[0] == (a[0] ^ b[0] ^ cin));
        assert_dominate_R3: assert ((carry_zero & ~carry_one) == '0);
        assert_select_R4: assert (carry_sel == (cin ? carry_one : carry_zero));
        assert_propagate_R5: assert (!(a == ~b) || (cout == cin && sum == {WIDTH{~cin}}));
        assert_generate_R6: assert (!(a[WIDTH-1] && b[WIDTH-1]) || cout);
        assert_kill_R7: assert ((a[WIDTH-1] || b[WIDTH-1]) || !cout);
    end
endmodule

bind csb_adder csb_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a          (a),
    .b          (b),
    .cin        (cin),
    .sum        (sum),
    .cout       (cout),
    .carry_zero (carry_zero),
    .carry_one  (carry_one),
    .carry_sel  (carry_sel)
);

// File: tb/csb_adder_bench.sv
// Bench: vector table at width 16, exhaustive width 4, random width 16.
module csb_adder_bench;
    localparam int W  = 16;
    localparam int WS = 4;
    localparam int NVEC = 9;
    localparam int NRAND = 1000;

    // {a, b, cin, cout, sum}
    localparam logic [2*W+2+W-1:0] VEC [NVEC] = '{
        {16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000},
        {16'hFFFF, 16'h0001, 1'b0, 1'b1, 16'h0000},
        {16'hFFFF, 16'h0000, 1'b1, 1'b1, 16'h0000},
        {16'h1234, 16'h4321, 1'b0, 1'b0, 16'h5555},
        {16'h8000, 16'h8000, 1'b0, 1'b1, 16'h0000},
        {16'hAAAA, 16'h5555, 1'b0, 1'b0, 16'hFFFF},
        {16'hAAAA, 16'h5555, 1'b1, 1'b1, 16'h0000},
        {16'h7FFF, 16'h0000, 1'b1, 1'b0, 16'h8000},
        {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0]  a, b, sum;
    logic          cin, cout;
    logic [WS-1:0] a4, b4, sum4;
    logic          cin4, cout4;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    csb_adder #(.WIDTH(W)) u_csb_adder (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    csb_adder #(.WIDTH(WS)) u_csb_adder_w4 (
        .a(a4), .b(b4), .cin(cin4), .sum(sum4), .cout(cout4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive16(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
        @(posedge clk);
        a = va; b = vb; cin = vc;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int n = 0; n < 100000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W:0] tot;
        logic       c_lo;
        a = '0; b = '0; cin = 1'b0;
        a4 = '0; b4 = '0; cin4 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle zero inputs give a zero result
        check("R1 idle", {15'd0, cout, sum}, 32'd0);

        // R1 table walk
        for (int k = 0; k < NVEC; k++) begin
            drive16(VEC[k][49:34], VEC[k][33:18], VEC[k][17]);
            check("R1 table", {15'd0, cout, sum}, {15'd0, VEC[k][16:0]});
        end

        // R1, R2, R3 exhaustive at width 4
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    @(posedge clk);
                    a4 = WS'(x); b4 = WS'(y); cin4 = c[0];
                    @(negedge clk);
                    check("R1 exhaustive", {27'd0, cout4, sum4}, 32'(x + y + c));
                    check("R2 lsb", {31'd0, sum4[0]}, {31'd0, a4[0] ^ b4[0] ^ cin4});
                    if (c == 0) c_lo = cout4;
                    else check("R3 monotonic", {31'd0, c_lo & ~cout4}, 32'd0);
                end
            end
        end

        // R4: cin picks the carry word; seen at cout via all-propagate plus carry-in
        drive16(16'h00FF, 16'hFF00, 1'b0);
        check("R4 pick zero", {15'd0, cout, sum}, {15'd0, 1'b0, 16'hFFFF});
        drive16(16'h00FF, 16'hFF00, 1'b1);
        check("R4 pick one", {15'd0, cout, sum}, {15'd0, 1'b1, 16'h0000});

        // R5: inverse operands
        for (int k = 0; k < 20; k++) begin
            logic [W-1:0] r;
            r = W'($urandom);
            drive16(r, ~r, 1'b1);
            check("R5 inverse cin1", {15'd0, cout, sum}, {15'd0, 1'b1, 16'h0000});
            drive16(r, ~r, 1'b0);
            check("R5 inverse cin0", {15'd0, cout, sum}, {15'd0, 1'b0, 16'hFFFF});
        end

        // R1, R6, R7 random width 16
        for (int k = 0; k < NRAND; k++) begin
            logic [W-1:0] ra, rb;
            logic         rc;
            ra = W'($urandom); rb = W'($urandom); rc = 1'($urandom);
            drive16(ra, rb, rc);
            tot = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
            check("R1 random", {15'd0, cout, sum}, {15'd0, tot});
            if (ra[W-1] && rb[W-1]) check("R6 generate", {31'd0, cout}, 32'd1);
            if (!ra[W-1] && !rb[W-1]) check("R7 kill", {31'd0, cout}, 32'd0);
        end

        // R6 and R7 directed corners
        drive16(16'h8000, 16'h8000, 1'b0);
        check("R6 corner", {31'd0, cout}, 32'd1);
        drive16(16'h7FFF, 16'h7FFF, 1'b1);
        check("R7 corner", {31'd0, cout}, 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule